// File: doc/BRIEF.md
# Two-Lane Signed 8-bit Dot-Product Accumulator

This block is a two-stage pipelined arithmetic unit for quantized inference kernels. Each accepted step presents two pairs of signed 8-bit operands. The block multiplies both pairs at once and sums the two products. It then adds that sum into a 24-bit running accumulator. A long dot product is therefore built up one step per clock cycle.

A second step kind, the merge step, bypasses the multipliers. It adds a 24-bit partial sum taken from a neighbouring unit into the accumulator, using the same 24-bit adder. A chain of these units can fold its partial results together in a reduction sweep. Any step may also carry a clear flag. A clear step loads the step's own contribution in place of the old accumulator value, which starts a new result without an idle cycle.

The result is signed two's complement and wraps modulo 2^24. Any signed overflow since the last clear step is recorded in a sticky flag. Results appear two clock cycles after the step is presented, and a one-cycle valid pulse marks each update.

Top module: `simd8_dot_acc`

## Requirements
- R1: After reset `acc_out` is 0, `acc_valid` is 0 and `acc_ovf` is 0.
- R2: A step with `step_valid`=1, `step_clear`=1 and `step_merge`=0 sets `acc_out` to the sign-extended value of op_a[7:0]*op_b[7:0] + op_a[15:8]*op_b[15:8]. Lane 0 is bits [7:0] and lane 1 is bits [15:8], and all operands are signed two's complement. `acc_valid` is 1 in the cycle that follows the second rising edge after the step.
- R3: A dot step with `step_clear`=0 adds the two-lane product sum to the previous `acc_out`, modulo 2^24.
- R4: A step with `step_clear`=1 discards the previous accumulator value, loads the step's contribution, and clears `acc_ovf`.
- R5: A step with `step_merge`=1 contributes `peer_sum` in place of the product sum, and the operand inputs have no effect on the result. It adds `peer_sum` to the accumulator, or loads it when `step_clear`=1.
- R6: When a non-clear step's signed addition leaves the range -2^23..2^23-1, `acc_out` takes the wrapped value and `acc_ovf` becomes 1. `acc_ovf` stays 1 until a clear step or reset.
- R7: A cycle with `step_valid`=0 leaves `acc_out` and `acc_ovf` unchanged, and two cycles later `acc_valid` is 0.
- R8: Steps may be presented on every cycle, in any mix of dot, merge and clear, with each result appearing exactly two cycles after its step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | A step is presented this cycle |
| step_clear | input | 1 | Load instead of accumulate |
| step_merge | input | 1 | Add peer_sum instead of the product sum |
| op_a | input | 16 | Two signed 8-bit operands, lane 0 in [7:0] |
| op_b | input | 16 | Two signed 8-bit operands, lane 0 in [7:0] |
| peer_sum | input | 24 | Partial sum from a neighbouring unit |
| acc_out | output | 24 | Accumulator value |
| acc_valid | output | 1 | Accumulator updated on the last edge |
| acc_ovf | output | 1 | Sticky signed-overflow flag |

## Verification
Two behaviours can fall on the same step. A clear can meet a merge, and a clear can land while the overflow flag is set. Whichever clear comes last must win: it loads the peer sum and drops the flag in one update.

The bench provokes both cases directly:
- It overflows the accumulator with a long run of extreme products and then issues a clear merge.
- It mixes clear, merge and idle steps at random.

Every cycle, the accumulator, valid flag and overflow flag are compared with a wide-integer model, two steps behind the stimulus.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;

    // Kind of work carried from the multiply stage to the add stage
    typedef enum logic [1:0] {
        STEP_NONE  = 2'd0,
        STEP_DOT   = 2'd1,
        STEP_MERGE = 2'd2
    } step_e;

endpackage

// File: rtl/dotacc_mul.sv
module dotacc_mul
    import dotacc_pkg::*;
#(
    parameter int LANES = 2,
    parameter int OP_W  = 8,
    parameter int ACC_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_clear,
    input  logic                   in_merge,
    input  logic [LANES*OP_W-1:0]  op_a,
    input  logic [LANES*OP_W-1:0]  op_b,
    input  logic [ACC_W-1:0]       peer,
    output step_e                  kind_o,
    output logic                   clr_o,
    output logic [ACC_W-1:0]       term_o
);
    localparam int PROD_W = 2 * OP_W;

    typedef struct packed {
        step_e              kind;
        logic               clr;
        logic [ACC_W-1:0]   term;
    } mul_st_t;

    mul_st_t          st_d, st_q;
    logic [ACC_W-1:0] prod [LANES];
    logic [ACC_W-1:0] dot_sum;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [PROD_W-1:0] p;
        assign p       = $signed(op_a[i*OP_W +: OP_W]) * $signed(op_b[i*OP_W +: OP_W]);
        assign prod[i] = {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    end

    always_comb begin
        dot_sum = '0;
        for (int i = 0; i < LANES; i++) begin
            dot_sum = dot_sum + prod[i];
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.kind = STEP_NONE;
        if (in_valid) begin
            st_d.kind = in_merge ? STEP_MERGE : STEP_DOT;
            st_d.clr  = in_clear;
            st_d.term = in_merge ? peer : dot_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{kind: STEP_NONE, clr: 1'b0, term: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign kind_o = st_q.kind;
    assign clr_o  = st_q.clr;
    assign term_o = st_q.term;

    // R5: a merge step forwards the peer sum untouched
    p_merge_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_merge) |=> (term_o == $past(peer) && kind_o == STEP_MERGE));

    // R7: no step presented means nothing forwarded
    p_idle_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (kind_o == STEP_NONE && $stable(term_o)));

endmodule

// File: rtl/dotacc_acc.sv
module dotacc_acc
    import dotacc_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             kind_i,
    input  logic              clr_i,
    input  logic [ACC_W-1:0]  term_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              vld_o,
    output logic              ovf_o
);
    localparam int MSB = ACC_W - 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             vld;
        logic             ovf;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic             step_on;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    assign step_on = (kind_i != STEP_NONE);

    always_comb begin
        sum  = st_q.acc + term_i;
        wrap = (st_q.acc[MSB] == term_i[MSB]) && (sum[MSB] != st_q.acc[MSB]);
        st_d = st_q;
        st_d.vld = step_on;
        if (step_on) begin
            if (clr_i) begin
                st_d.acc = term_i;
                st_d.ovf = 1'b0;
            end else begin
                st_d.acc = sum;
                st_d.ovf = st_q.ovf | wrap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{acc: '0, vld: 1'b0, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;
    assign vld_o = st_q.vld;
    assign ovf_o = st_q.ovf;

    // R2: each forwarded step produces one valid pulse a cycle later
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_on |=> vld_o);

    // R4: a clear step loads its contribution and drops the flag
    p_clear_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_on && clr_i) |=> (acc_o == $past(term_i) && !ovf_o));

    // R6: the overflow flag survives every step that is not a clear
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !(step_on && clr_i)) |=> ovf_o);

    // R7: idle cycles hold the accumulator and emit no valid
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_on |=> ($stable(acc_o) && $stable(ovf_o) && !vld_o));

endmodule

// File: rtl/simd8_dot_acc.sv
module simd8_dot_acc
    import dotacc_pkg::*;
#(
    parameter int LANES = 2,
    parameter int OP_W  = 8,
    parameter int ACC_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_valid,
    input  logic                   step_clear,
    input  logic                   step_merge,
    input  logic [LANES*OP_W-1:0]  op_a,
    input  logic [LANES*OP_W-1:0]  op_b,
    input  logic [ACC_W-1:0]       peer_sum,
    output logic [ACC_W-1:0]       acc_out,
    output logic                   acc_valid,
    output logic                   acc_ovf
);
    step_e            s1_kind;
    logic             s1_clr;
    logic [ACC_W-1:0] s1_term;

    dotacc_mul #(.LANES(LANES), .OP_W(OP_W), .ACC_W(ACC_W)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (step_valid),
        .in_clear (step_clear),
        .in_merge (step_merge),
        .op_a     (op_a),
        .op_b     (op_b),
        .peer     (peer_sum),
        .kind_o   (s1_kind),
        .clr_o    (s1_clr),
        .term_o   (s1_term)
    );

    dotacc_acc #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind_i (s1_kind),
        .clr_i  (s1_clr),
        .term_i (s1_term),
        .acc_o  (acc_out),
        .vld_o  (acc_valid),
        .ovf_o  (acc_ovf)
    );

    // R8: a step is seen at the output exactly two edges later
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> ##1 acc_valid);

endmodule

// File: tb/tb_simd8_dot_acc.sv
module tb_simd8_dot_acc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_valid = 1'b0, step_clear = 1'b0, step_merge = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic [23:0] peer_sum = '0;
    logic [23:0] acc_out;
    logic        acc_valid, acc_ovf;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    // model state and a two-deep delay line of expected outputs
    logic [23:0] m_acc = '0;
    logic        m_ovf = 1'b0;
    logic [23:0] dl_acc [2];
    logic        dl_vld [2];
    logic        dl_ovf [2];
    string       dl_tag [2];

    simd8_dot_acc dut (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_clear(step_clear),
        .step_merge(step_merge), .op_a(op_a), .op_b(op_b), .peer_sum(peer_sum),
        .acc_out(acc_out), .acc_valid(acc_valid), .acc_ovf(acc_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int dot2(logic [15:0] a, logic [15:0] b);
        int p0, p1;
        p0 = int'($signed(a[7:0])) * int'($signed(b[7:0]));
        p1 = int'($signed(a[15:8])) * int'($signed(b[15:8]));
        return p0 + p1;
    endfunction

    function automatic int as_s24(logic [23:0] v);
        return int'($signed(v));
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic check_out(string tag, logic [23:0] ea, logic ev, logic eo);
        n_vec++;
        if (acc_out !== ea || acc_valid !== ev || acc_ovf !== eo) begin
            n_bad++;
            $display("FAIL %s: acc=%h valid=%b ovf=%b expected acc=%h valid=%b ovf=%b",
                     tag, acc_out, acc_valid, acc_ovf, ea, ev, eo);
        end
    endtask

    // called at a falling edge: checks the step from two cycles back, then drives a new one
    task automatic step(string tag, logic v, logic c, logic m,
                        logic [15:0] a, logic [15:0] b, logic [23:0] p);
        int t, full;
        check_out(dl_tag[1], dl_acc[1], dl_vld[1], dl_ovf[1]);
        if (v) begin
            t = m ? as_s24(p) : dot2(a, b);
            if (c) begin
                m_acc = t[23:0];
                m_ovf = 1'b0;
            end else begin
                full = as_s24(m_acc) + t;
                if (full > 8388607 || full < -8388608) m_ovf = 1'b1;
                m_acc = full[23:0];
            end
        end
        dl_acc[1] = dl_acc[0]; dl_vld[1] = dl_vld[0]; dl_ovf[1] = dl_ovf[0]; dl_tag[1] = dl_tag[0];
        dl_acc[0] = m_acc;     dl_vld[0] = v;         dl_ovf[0] = m_ovf;     dl_tag[0] = tag;
        step_valid = v; step_clear = c; step_merge = m;
        op_a = a; op_b = b; peer_sum = p;
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int seed;
        logic v, c, m;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int i = 0; i < 2; i++) begin
            dl_acc[i] = '0; dl_vld[i] = 1'b0; dl_ovf[i] = 1'b0; dl_tag[i] = "R1";
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check_out("R1", 24'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", 24'h0, 1'b0, 1'b0);

        // R2: clear dot with mixed signs
        step("R2", 1, 1, 0, {8'd3, 8'hFB}, {8'hF9, 8'd7}, 24'h0);   // 3*-7 + -5*7 = -56
        // R3: accumulate
        step("R3", 1, 0, 0, {8'd100, 8'd127}, {8'd2, 8'd127}, 24'h0);
        step("R3", 1, 0, 0, {8'h80, 8'h80}, {8'd127, 8'h80}, 24'h0);
        // R7: idle with busy operand pins
        step("R7", 0, 1, 1, 16'hFFFF, 16'h8080, 24'h123456);
        step("R7", 0, 0, 0, 16'h7F7F, 16'h7F7F, 24'h7FFFFF);
        // R6: drive past +2^23-1 with (-128)^2 twice per step
        step("R6", 1, 1, 0, 16'h8080, 16'h8080, 24'h0);
        for (int i = 0; i < 258; i++) step("R6", 1, 0, 0, 16'h8080, 16'h8080, 24'h0);
        step("R6", 0, 0, 0, 16'h0, 16'h0, 24'h0);
        // R4: clear while overflow is set, combined with merge
        step("R4", 1, 1, 1, 16'h7F7F, 16'h7F7F, 24'h000010);
        // R5: merge ignores operands, then wraps at the negative end
        step("R5", 1, 0, 1, 16'h8080, 16'h8080, 24'hFFFFF0);
        step("R5", 1, 1, 1, 16'h1234, 16'h5678, 24'h800000);
        step("R6", 1, 0, 1, 16'h0, 16'h0, 24'hFFFFFF);
        step("R4", 1, 1, 0, 16'h0101, 16'h0101, 24'h0);
        // R8: back-to-back random stream
        for (int i = 0; i < 3000; i++) begin
            v = ($urandom % 4) != 0;
            c = ($urandom % 16) == 0;
            m = ($urandom % 4) == 0;
            step("R8", v, c, m, 16'($urandom), 16'($urandom), 24'($urandom));
        end
        // drain the pipeline
        step("R8", 0, 0, 0, 16'h0, 16'h0, 24'h0);
        step("R8", 0, 0, 0, 16'h0, 16'h0, 24'h0);
        check_out(dl_tag[1], dl_acc[1], dl_vld[1], dl_ovf[1]);
        finish_run();
    end
endmodule